// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits behind the receive path of an Ethernet MAC and decides whether a frame is kept, based on the first six bytes of the frame: the 48-bit destination address. The bytes arrive on a valid/ready byte stream, and `in_start` marks the first byte of each address. The block keeps two results. One is a running exact comparison against a programmed station address. The other is a CRC-32 hash whose top six bits pick one bit out of a 64-bit individual-address table. The frame is accepted when either result is true.

The CRC runs the reflected polynomial 0xEDB88320. It starts at all ones and takes each address byte least-significant bit first. It does no final inversion. The index is bits 31:26 of the CRC after the 48th data bit. The engine is built in one of two forms, chosen by a parameter: a byte-parallel form that takes one byte per cycle, or a bit-serial form that takes eight cycles per byte and holds back the stream with `in_ready` while it works.

The same datapath also computes table values. When `cfg_mode` is high at the time an address completes, the block reports no accept or hit. Instead it drives the one-hot 64-bit table value for that address on `cfg_tbl_upper`/`cfg_tbl_lower`, and software can copy that value into the table registers. Stream rules are as follows. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` and the byte for as long as it likes. `in_ready` never depends on `in_valid`.

Top module: `dest_addr_filter`

## Requirements
- R1: `hash_index` equals bits 31:26 of a CRC computed as follows. The CRC starts at 0xFFFFFFFF. For each of the six bytes, bit 0 first, the CRC shifts right by one, and it is then XORed with 0xEDB88320 when the data bit differs from the old CRC bit 0.
- R2: `hash_hit` is bit (index−32) of `hash_tbl_upper` when the index is 32 or more, and bit index of `hash_tbl_lower` when it is smaller.
- R3: `exact_hit` is high only when all six bytes equal the station address. Bytes 0 to 3 are compared with `station_w0[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Bytes 4 and 5 are compared with `station_w1[31:24]` and `[23:16]`. The port `station_w1` covers only bits 31:16 of its register; the low half, which holds the type value, is not connected.
- R4: When `cfg_mode` is low at completion, `accept` equals `exact_hit` OR `hash_hit`.
- R5: In the byte-parallel build, `res_valid` rises in the cycle after the edge that takes the sixth byte, and not earlier.
- R6: The byte-parallel build holds `in_ready` high. The bit-serial build drops `in_ready` for exactly 8 cycles after each byte it takes.
- R7: A byte taken with `in_start` high becomes byte 0 of a new address. On the next cycle `res_valid`, `accept` and both hit flags are low, and an address that was only partly received is discarded.
- R8: Bytes taken with `in_start` low after the sixth byte, or before any start after reset, change nothing. The result outputs keep their values.
- R9: When `cfg_mode` is high at completion, `accept`, `hash_hit` and `exact_hit` are low. `{cfg_tbl_upper, cfg_tbl_lower}` is then one-hot at bit `hash_index`. In filter mode that pair is zero.
- R10: The bit-serial build produces the same results as the byte-parallel build. The result appears 8 cycles after the sixth byte is taken.
- R11: After reset, `res_valid`, all flags, `hash_index` and both `cfg_tbl` words are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Address byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_start | input | 1 | Marks byte 0 of an address |
| in_byte | input | 8 | Address byte |
| cfg_mode | input | 1 | 1: produce a table value, 0: filter |
| hash_tbl_upper | input | 32 | Table bits for indices 63..32 |
| hash_tbl_lower | input | 32 | Table bits for indices 31..0 |
| station_w0 | input | 32 | Station address bytes 0 to 3 |
| station_w1 | input | 16 | Bits 31:16 of the second station register (bytes 4 and 5) |
| res_valid | output | 1 | Result present, held until the next start |
| accept | output | 1 | Frame accepted |
| hash_hit | output | 1 | Selected table bit set |
| exact_hit | output | 1 | Station address matched |
| hash_index | output | 6 | Computed hash index |
| cfg_tbl_upper | output | 32 | One-hot table value, upper word |
| cfg_tbl_lower | output | 32 | One-hot table value, lower word |

## Verification
A sweep of pseudo-random addresses with changing tables covers indices on both sides of 32. That separates a wrong polynomial, bit order or table half from a correct one. The station address is mixed into the sweep, along with six near-misses, each differing in a single byte. These tell a real six-byte compare from a partial one or one with the byte order reversed. Further sequences cover aborted and back-to-back starts, trailing and orphan bytes, and the round trip in which a configuration-mode table value is loaded back into the table. Both builds run the same patterns. The serial build is also checked for its ready timing.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned HASH_W     = 6;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFFFFFF;

  function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] c, input logic d);
    if (d ^ c[0]) return (c >> 1) ^ CRC_POLY_REFL;
    else          return c >> 1;
  endfunction

  function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] c,
                                                     input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) r = crc_bit_step(r, b[i]);
    return r;
  endfunction
endpackage

// File: rtl/addr_crc_engine.sv
module addr_crc_engine
  import addr_filter_pkg::*;
#(
  parameter bit BIT_SERIAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              absorb,
  input  logic              reload,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tag_last,
  output logic              ready,
  output logic              done,
  output logic              done_last,
  output logic [CRC_W-1:0]  crc_next
);
  generate
    if (BIT_SERIAL == 1'b0) begin : g_par
      logic [CRC_W-1:0] crc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= CRC_SEED;
        else if (absorb) crc_q <= crc_next;
      end
      always_comb crc_next = crc_byte_step(reload ? CRC_SEED : crc_q, byte_in);
      assign ready     = 1'b1;
      assign done      = absorb;
      assign done_last = absorb && tag_last;
    end else begin : g_ser
      localparam int unsigned STEP_W = $clog2(BYTE_W);
      localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(BYTE_W - 1);
      logic [CRC_W-1:0]  crc_q;
      logic [BYTE_W-1:0] sh_q;
      logic [STEP_W-1:0] step_q;
      logic              busy_q, last_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          crc_q  <= CRC_SEED;
          sh_q   <= '0;
          step_q <= '0;
          busy_q <= 1'b0;
          last_q <= 1'b0;
        end else if (absorb) begin
          crc_q  <= reload ? CRC_SEED : crc_q;
          sh_q   <= byte_in;
          step_q <= '0;
          busy_q <= 1'b1;
          last_q <= tag_last;
        end else if (busy_q) begin
          crc_q  <= crc_next;
          sh_q   <= sh_q >> 1;
          step_q <= step_q + 1'b1;
          if (step_q == STEP_LAST) busy_q <= 1'b0;
        end
      end
      always_comb crc_next = crc_bit_step(crc_q, sh_q[0]);
      assign ready     = !busy_q;
      assign done      = busy_q && (step_q == STEP_LAST);
      assign done_last = done && last_q;

      // R6
      absorb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        absorb |=> (busy_q && !ready));
      // R6
      ready_after_last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    end
  endgenerate
endmodule

// File: rtl/addr_exact_cmp.sv
module addr_exact_cmp
  import addr_filter_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [31:0]       station_w0,
  input  logic [31:16]      station_w1,
  output logic              match_now
);
  localparam int unsigned STA_W = ADDR_BYTES * BYTE_W;
  logic [STA_W-1:0]  sta;
  logic [BYTE_W-1:0] exp_byte;
  logic              match_q, match_nx;

  assign sta = {station_w0, station_w1};

  always_comb begin
    exp_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (idx == IDX_W'(i)) exp_byte = sta[STA_W-1-i*BYTE_W -: BYTE_W];
  end

  assign match_nx  = (first || match_q) && (byte_in == exp_byte);
  assign match_now = take ? match_nx : match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    match_q <= 1'b0;
    else if (take) match_q <= match_nx;
  end

  // R3
  take_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (idx < IDX_W'(ADDR_BYTES)));
endmodule

// File: rtl/hash_tbl_select.sv
module hash_tbl_select
  import addr_filter_pkg::*;
(
  input  logic [HASH_W-1:0] index,
  input  logic [31:0]       tbl_upper,
  input  logic [31:0]       tbl_lower,
  output logic              hit,
  output logic [31:0]       onehot_upper,
  output logic [31:0]       onehot_lower
);
  localparam int unsigned TBL_BITS = 1 << HASH_W;
  logic [TBL_BITS-1:0] full, onehot;

  assign full   = {tbl_upper, tbl_lower};
  assign hit    = full[index];
  assign onehot = TBL_BITS'(1) << index;
  assign {onehot_upper, onehot_lower} = onehot;

  // R9
  always_comb begin
    onehot_shape_chk: assert ($onehot({onehot_upper, onehot_lower}));
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filter_pkg::*;
#(
  parameter bit BIT_SERIAL = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_start,
  input  logic [7:0]  in_byte,
  input  logic        cfg_mode,
  input  logic [31:0] hash_tbl_upper,
  input  logic [31:0] hash_tbl_lower,
  input  logic [31:0] station_w0,
  input  logic [31:16] station_w1,
  output logic        res_valid,
  output logic        accept,
  output logic        hash_hit,
  output logic        exact_hit,
  output logic [5:0]  hash_index,
  output logic [31:0] cfg_tbl_upper,
  output logic [31:0] cfg_tbl_lower
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]  byte_cnt_q, idx;
  logic              hs, take, tag_last;
  logic              eng_ready, eng_done, eng_done_last;
  logic [CRC_W-1:0]  crc_next;
  logic [HASH_W-1:0] idx_now;
  logic              match_now, tbl_hit;
  logic [31:0]       oh_up, oh_lo;

  assign hs       = in_valid && in_ready;
  assign take     = hs && (in_start || byte_cnt_q != CNT_IDLE);
  assign idx      = in_start ? '0 : byte_cnt_q;
  assign tag_last = (idx == CNT_LAST);
  assign in_ready = eng_ready;
  assign idx_now  = crc_next[CRC_W-1 -: HASH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    byte_cnt_q <= CNT_IDLE;
    else if (take) byte_cnt_q <= idx + 1'b1;
  end

  addr_crc_engine #(.BIT_SERIAL(BIT_SERIAL)) u_crc (
    .clk, .rst_n, .absorb(take), .reload(in_start), .byte_in(in_byte),
    .tag_last, .ready(eng_ready), .done(eng_done), .done_last(eng_done_last),
    .crc_next
  );

  addr_exact_cmp #(.IDX_W(CNT_W)) u_cmp (
    .clk, .rst_n, .take, .first(in_start), .idx, .byte_in(in_byte),
    .station_w0, .station_w1, .match_now
  );

  hash_tbl_select u_sel (
    .index(idx_now), .tbl_upper(hash_tbl_upper), .tbl_lower(hash_tbl_lower),
    .hit(tbl_hit), .onehot_upper(oh_up), .onehot_lower(oh_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; accept <= 1'b0; hash_hit <= 1'b0; exact_hit <= 1'b0;
      hash_index <= '0; cfg_tbl_upper <= '0; cfg_tbl_lower <= '0;
    end else if (take && in_start) begin
      res_valid <= 1'b0; accept <= 1'b0; hash_hit <= 1'b0; exact_hit <= 1'b0;
      hash_index <= '0; cfg_tbl_upper <= '0; cfg_tbl_lower <= '0;
    end else if (eng_done_last) begin
      res_valid  <= 1'b1;
      hash_index <= idx_now;
      if (cfg_mode) begin
        accept <= 1'b0; hash_hit <= 1'b0; exact_hit <= 1'b0;
        cfg_tbl_upper <= oh_up; cfg_tbl_lower <= oh_lo;
      end else begin
        accept    <= tbl_hit || match_now;
        hash_hit  <= tbl_hit;
        exact_hit <= match_now;
        cfg_tbl_upper <= '0; cfg_tbl_lower <= '0;
      end
    end
  end

  generate
    if (BIT_SERIAL == 1'b0) begin : g_par_chk
      // R5
      last_byte_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_start && byte_cnt_q == CNT_LAST) |=> res_valid);
      // R6
      par_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
    end
  endgenerate

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && in_start) |=> (!res_valid && !accept && !hash_hit && !exact_hit));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(hs && in_start)) |=> (res_valid && $stable(hash_index) && $stable(accept)));
  // R4
  accept_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_hit || exact_hit) |-> accept);
  // R9
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_tbl_upper | cfg_tbl_lower) != '0) |-> (!accept && res_valid));
endmodule

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic v0 = 1'b0, v1 = 1'b0, in_start = 1'b0, cfg_mode = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [31:0] tbl_u = '0, tbl_l = '0, sw0 = '0;
  logic [31:16] sw1 = '0;

  logic r0, rv0, ac0, hh0, eh0; logic [5:0] ix0; logic [31:0] cu0, cl0;
  logic r1, rv1, ac1, hh1, eh1; logic [5:0] ix1; logic [31:0] cu1, cl1;

  int checks = 0, fails = 0;
  logic [47:0] station;

  dest_addr_filter #(.BIT_SERIAL(1'b0)) dut (
    .clk, .rst_n, .in_valid(v0), .in_ready(r0), .in_start, .in_byte, .cfg_mode,
    .hash_tbl_upper(tbl_u), .hash_tbl_lower(tbl_l), .station_w0(sw0), .station_w1(sw1),
    .res_valid(rv0), .accept(ac0), .hash_hit(hh0), .exact_hit(eh0), .hash_index(ix0),
    .cfg_tbl_upper(cu0), .cfg_tbl_lower(cl0));

  dest_addr_filter #(.BIT_SERIAL(1'b1)) dut_ser (
    .clk, .rst_n, .in_valid(v1), .in_ready(r1), .in_start, .in_byte, .cfg_mode,
    .hash_tbl_upper(tbl_u), .hash_tbl_lower(tbl_l), .station_w0(sw0), .station_w1(sw1),
    .res_valid(rv1), .accept(ac1), .hash_hit(hh1), .exact_hit(eh1), .hash_index(ix1),
    .cfg_tbl_upper(cu1), .cfg_tbl_lower(cl1));

  function automatic logic [5:0] model_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = a[47-8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        if (by[k] != c[0]) c = (c >> 1) ^ 32'hEDB88320;
        else               c = c >> 1;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t = s;
    t ^= t << 13; t ^= t >> 7; t ^= t << 17;
    return t;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // send one byte to the selected instances; returns at the negedge after the last accept
  task automatic send_byte(input logic [7:0] b, input logic st, input bit u0, input bit u1);
    bit a0, a1;
    in_byte = b; in_start = st; v0 = u0; v1 = u1;
    while (v0 || v1) begin
      a0 = v0 && r0; a1 = v1 && r1;
      @(posedge clk); @(negedge clk);
      if (a0) v0 = 1'b0;
      if (a1) v1 = 1'b0;
    end
    in_start = 1'b0;
  endtask

  task automatic send_addr(input logic [47:0] a, input bit u0, input bit u1);
    for (int b = 0; b < 6; b++) send_byte(a[47-8*b -: 8], b == 0, u0, u1);
  endtask

  task automatic check_both(input logic [47:0] a, input string tag);
    logic [5:0] ei = model_index(a);
    logic eh = ei[5] ? tbl_u[ei[4:0]] : tbl_l[ei[4:0]];
    logic ee = (a == station);
    logic [63:0] oh = cfg_mode ? (64'd1 << ei) : 64'd0;
    chk({"R1 index ", tag}, ix0, ei);
    chk({"R2 hash_hit ", tag}, hh0, cfg_mode ? 1'b0 : eh);
    chk({"R3 exact_hit ", tag}, eh0, cfg_mode ? 1'b0 : ee);
    chk({"R4 accept ", tag}, ac0, cfg_mode ? 1'b0 : (eh || ee));
    chk({"R9 cfg table ", tag}, {cu0, cl0}, oh);
    chk({"R10 serial valid ", tag}, rv1, 1'b1);
    chk({"R10 serial index/flags ", tag}, {ix1, hh1, eh1, ac1}, {ix0, hh0, eh0, ac0});
    chk({"R10 serial cfg table ", tag}, {cu1, cl1}, oh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] s = 64'h0123_4567_89AB_CDEF;
    logic [47:0] a, b;
    int cnt;
    station = 48'h02_1A_3C_5E_70_9F;
    sw0 = station[47:16]; sw1 = station[15:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {rv0, ac0, hh0, eh0, ix0, cu0, cl0}, '0);
    chk("R11 reset serial outputs", {rv1, ac1, ix1, cu1, cl1}, '0);
    chk("R11 ready after reset", {r0, r1}, 2'b11);

    // R8 bytes before any start are ignored
    for (int k = 0; k < 6; k++) send_byte(8'h11 * k, 1'b0, 1'b1, 1'b1);
    repeat (9) @(negedge clk);
    chk("R8 orphan bytes no result", {rv0, rv1, ix0, ix1}, '0);

    // R5 latency, parallel build
    a = 48'hA1_B2_C3_D4_E5_F6;
    for (int k = 0; k < 5; k++) send_byte(a[47-8*k -: 8], k == 0, 1'b1, 1'b0);
    chk("R5 no result before sixth byte", rv0, 1'b0);
    send_byte(a[7:0], 1'b0, 1'b1, 1'b0);
    chk("R5 result one cycle after sixth byte", rv0, 1'b1);
    chk("R5 index", ix0, model_index(a));
    chk("R6 parallel ready high", r0, 1'b1);

    // R7 start clears result
    send_byte(8'h00, 1'b1, 1'b1, 1'b0);
    chk("R7 start clears result", {rv0, ac0, hh0, eh0}, 4'b0);

    // R6 serial ready timing
    send_byte(8'h5A, 1'b1, 1'b0, 1'b1);
    cnt = 0;
    while (!r1 && cnt < 20) begin cnt++; @(negedge clk); end
    chk("R6 serial busy cycles", cnt, 8);

    // R10 serial latency: result exactly 8 cycles after sixth byte
    a = 48'h33_44_55_66_77_88;
    for (int k = 0; k < 6; k++) send_byte(a[47-8*k -: 8], k == 0, 1'b0, 1'b1);
    repeat (7) @(negedge clk);
    chk("R10 serial not yet valid", rv1, 1'b0);
    @(negedge clk);
    chk("R10 serial valid after 8 steps", rv1, 1'b1);
    chk("R10 serial index", ix1, model_index(a));

    // R3/R4 exact match and single-byte near-misses with empty table
    tbl_u = '0; tbl_l = '0; cfg_mode = 1'b0;
    send_addr(station, 1'b1, 1'b1); repeat (8) @(negedge clk);
    check_both(station, "station exact");
    for (int p = 0; p < 6; p++) begin
      a = station ^ (48'd1 << (8*(5-p) + p));
      send_addr(a, 1'b1, 1'b1); repeat (8) @(negedge clk);
      check_both(a, "near miss");
      chk("R3 near miss rejected", {eh0, ac0}, 2'b00);
    end

    // R7 aborted address followed by a full one
    a = 48'hDE_AD_BE_EF_00_01;
    for (int k = 0; k < 3; k++) send_byte(8'hF0 + k, k == 0, 1'b1, 1'b1);
    send_addr(a, 1'b1, 1'b1); repeat (8) @(negedge clk);
    chk("R7 aborted address discarded", ix0, model_index(a));
    check_both(a, "restart");

    // R8 trailing bytes ignored
    for (int k = 0; k < 4; k++) send_byte(8'hC3 ^ k, 1'b0, 1'b1, 1'b1);
    repeat (9) @(negedge clk);
    chk("R8 trailing bytes hold result", {rv0, ix0, rv1, ix1}, {1'b1, model_index(a), 1'b1, model_index(a)});

    // R9 round trip: config value loaded back into the table
    a = 48'h01_00_5E_00_00_FB;
    cfg_mode = 1'b1;
    send_addr(a, 1'b1, 1'b1); repeat (8) @(negedge clk);
    check_both(a, "cfg");
    tbl_u = cu0; tbl_l = cl0; cfg_mode = 1'b0;
    send_addr(a, 1'b1, 1'b1); repeat (8) @(negedge clk);
    chk("R9 loaded table hits", {hh0, ac0, hh1}, 3'b111);
    b = a ^ 48'h1;
    while (model_index(b) == model_index(a)) b = b ^ 48'h100;
    send_addr(b, 1'b1, 1'b1); repeat (8) @(negedge clk);
    chk("R2 other index misses", {hh0, hh1}, 2'b00);

    // sweep
    for (int n = 0; n < 256; n++) begin
      if (n % 16 == 0) begin
        s = xs(s); tbl_u = s[31:0]; tbl_l = s[63:32];
      end
      s = xs(s); a = s[47:0];
      if (n % 8 == 3) a = station;
      cfg_mode = (n % 4 == 1);
      send_addr(a, 1'b1, 1'b1); repeat (8) @(negedge clk);
      check_both(a, "sweep");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule